// File: doc/BRIEF.md
# Relocatable SRAM Window Controller

This block sits between a simple register-style bus and an on-chip static RAM array. It maps the array into a window of the address space whose position software chooses. It filters every array access against a space-restriction code built from two bus qualifiers: program versus data fetch, and supervisor versus user privilege. It also offers a stop mode in which the array is left untouched.

A configuration register and two base-address registers are reached through the same bus port. The configuration register holds the stop bit, a sticky power-status flag, a base-lock bit and the two-bit space code. The base registers hold the upper address bits of the window.

For each request the controller either serves a register, drives the array's chip select and write enable, or reports the array cycle as ignored. Read data returns one cycle after the request, together with a valid strobe. A single input models loss of standby power.

Top module: `sram_window_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x0300 (space code 11, all other bits 0), and both base registers read 0x0000.
- R2: The configuration register is at 0xFFFB00. Bit 15 is stop, bit 12 is power status, bit 11 is base lock and bits 9:8 are the space code. Every other bit reads 0.
- R3: The upper base register (0xFFFB04) holds address bits 23:16 in its bits 7:0. The lower base register (0xFFFB06) holds address bits 15:10 in its bits 15:10, and its lower bits read 0. An access hits the array when address bits 23:10 equal this stored field.
- R4: The space code decides which hits are allowed. 00 allows all accesses. 01 allows program accesses only (bus_prog=1). 10 allows supervisor accesses only (bus_super=1). 11 allows only supervisor program accesses.
- R5: While stop is 1, no array read or write takes place, and every hit is reported as ignored.
- R6: While base lock is 1, writes to either base register are discarded.
- R7: A high power_lost clears power status. A write of 1 to bit 12 sets it again only while power_lost is low. A write of 0 to bit 12 has no effect on it.
- R8: One cycle after a hit, exactly one of acc_done (accepted) and acc_ignored pulses for a single cycle. A request that misses both the window and the registers pulses neither.
- R9: A register address takes priority over the array window. A register access never drives the array and never reports an array outcome.
- R10: A read of a register or an accepted array read sets bus_rvalid with the data one cycle after the request. Writes and ignored reads do not set bus_rvalid.
- R11: Data written to the array by an accepted write is returned by a later accepted read of the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_prog | input | 1 | 1 = program-space access, 0 = data-space |
| bus_super | input | 1 | 1 = supervisor privilege |
| power_lost | input | 1 | Standby power failure indication |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after request |
| acc_done | output | 1 | Array access accepted (one-cycle pulse) |
| acc_ignored | output | 1 | Array hit rejected (one-cycle pulse) |

## Verification
The assertions watch several rules on every cycle. The array select stays off during stop and during register cycles, and the two outcome pulses are mutually exclusive. The base field holds still while the lock bit is set, and power status drops after a power loss. Read strobes occur only after a read request. Only the directed scenarios can show the rest: the full space-code table across all qualifier combinations, window relocation to a new base, data integrity through the array, and the re-arm rule for power status.

// File: rtl/sramw_pkg.sv
package sramw_pkg;

   localparam int CFG_STOP_BIT  = 15;
   localparam int CFG_PWR_BIT   = 12;
   localparam int CFG_LOCK_BIT  = 11;
   localparam int CFG_SPACE_LSB = 8;

   typedef struct packed {
      logic       stop;
      logic       pwr_ok;
      logic       lock;
      logic [1:0] space;
   } cfg_t;

   function automatic logic [15:0] cfg_image(input cfg_t c);
      logic [15:0] v;
      v = '0;
      v[CFG_STOP_BIT]                     = c.stop;
      v[CFG_PWR_BIT]                      = c.pwr_ok;
      v[CFG_LOCK_BIT]                     = c.lock;
      v[CFG_SPACE_LSB+1:CFG_SPACE_LSB]    = c.space;
      return v;
   endfunction

endpackage

// File: rtl/sramw_cfg_regs.sv
module sramw_cfg_regs
   import sramw_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          DATA_W      = 16,
   parameter int          OFS_W       = 10,
   parameter logic [31:0] CFG_ADDR    = 32'h00FF_FB00,
   parameter logic [31:0] BASEH_ADDR  = 32'h00FF_FB04,
   parameter logic [31:0] BASEL_ADDR  = 32'h00FF_FB06,
   parameter bit          HAS_PWR_MON = 1'b1,
   localparam int         BASE_W      = ADDR_W - OFS_W,
   localparam int         HI_W        = ADDR_W - 16,
   localparam int         LO_W        = 16 - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              power_lost,
   output logic              reg_hit,
   output cfg_t              cfg,
   output logic [BASE_W-1:0] base_field,
   output logic [DATA_W-1:0] reg_rdata
);

   logic sel_cfg, sel_bh, sel_bl;
   logic wr_cfg, wr_bh, wr_bl;
   logic [BASE_W-1:0] base_q;
   logic       stop_q, lock_q;
   logic [1:0] space_q;
   logic       pwr_ok;

   assign sel_cfg = (addr == CFG_ADDR[ADDR_W-1:0]);
   assign sel_bh  = (addr == BASEH_ADDR[ADDR_W-1:0]);
   assign sel_bl  = (addr == BASEL_ADDR[ADDR_W-1:0]);
   assign reg_hit = req & (sel_cfg | sel_bh | sel_bl);

   assign wr_cfg = req & wr & sel_cfg;
   assign wr_bh  = req & wr & sel_bh & ~lock_q;
   assign wr_bl  = req & wr & sel_bl & ~lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q  <= 1'b0;
         lock_q  <= 1'b0;
         space_q <= 2'b11;
      end else if (wr_cfg) begin
         stop_q  <= wdata[CFG_STOP_BIT];
         lock_q  <= wdata[CFG_LOCK_BIT];
         space_q <= wdata[CFG_SPACE_LSB+1:CFG_SPACE_LSB];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else begin
         if (wr_bh) base_q[BASE_W-1:LO_W] <= wdata[HI_W-1:0];
         if (wr_bl) base_q[LO_W-1:0]      <= wdata[15:OFS_W];
      end
   end

   generate
      if (HAS_PWR_MON) begin : g_pwr_mon
         logic pwr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  pwr_q <= 1'b0;
            else if (power_lost)                         pwr_q <= 1'b0;
            else if (wr_cfg && wdata[CFG_PWR_BIT])       pwr_q <= 1'b1;
         end
         assign pwr_ok = pwr_q;
         AST_PWR_DROP: assert property (@(posedge clk) disable iff (!rst_n) power_lost |=> !pwr_ok) else $error("power status kept after loss"); // R7
      end else begin : g_no_pwr_mon
         assign pwr_ok = 1'b0;
      end
   endgenerate

   assign cfg.stop   = stop_q;
   assign cfg.pwr_ok = pwr_ok;
   assign cfg.lock   = lock_q;
   assign cfg.space  = space_q;
   assign base_field = base_q;

   always_comb begin
      reg_rdata = '0;
      if (sel_cfg)     reg_rdata = cfg_image(cfg);
      else if (sel_bh) reg_rdata[HI_W-1:0] = base_q[BASE_W-1:LO_W];
      else if (sel_bl) reg_rdata[15:OFS_W] = base_q[LO_W-1:0];
   end

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> $stable(base_q)) else $error("base moved while locked"); // R6

endmodule

// File: rtl/sramw_decode.sv
module sramw_decode
   import sramw_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int OFS_W        = 10,
   parameter int IDX_W        = 9,
   parameter bit SPACE_FILTER = 1'b1,
   localparam int BASE_W      = ADDR_W - OFS_W,
   localparam int WB_W        = OFS_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              prog,
   input  logic              super_acc,
   input  logic              reg_hit,
   input  logic [BASE_W-1:0] base_field,
   input  cfg_t              cfg,
   output logic              arr_cs,
   output logic              arr_we,
   output logic              ignore,
   output logic [IDX_W-1:0]  arr_idx
);

   logic in_window, space_ok, hit;

   assign in_window = (addr[ADDR_W-1:OFS_W] == base_field);
   assign hit       = req & in_window & ~reg_hit;

   generate
      if (SPACE_FILTER) begin : g_filter
         logic need_super, need_prog;
         assign need_super = cfg.space[1];
         assign need_prog  = cfg.space[0];
         assign space_ok   = (~need_super | super_acc) & (~need_prog | prog);
      end else begin : g_open
         assign space_ok = 1'b1;
      end
   endgenerate

   assign arr_cs  = hit & ~cfg.stop & space_ok;
   assign arr_we  = arr_cs & wr;
   assign ignore  = hit & (cfg.stop | ~space_ok);
   assign arr_idx = addr[OFS_W-1:WB_W];

   AST_REG_FIRST: assert property (@(posedge clk) disable iff (!rst_n) reg_hit |-> !arr_cs && !ignore) else $error("register cycle touched array"); // R9
   AST_SUPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (arr_cs && SPACE_FILTER && cfg.space[1]) |-> super_acc) else $error("user access passed supervisor code"); // R4

endmodule

// File: rtl/sramw_array.sv
module sramw_array #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 512,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              cs,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (cs) begin
         if (we) mem[idx] <= wdata;
         else    rdata    <= mem[idx];
      end
   end

endmodule

// File: rtl/sram_window_ctrl.sv
module sram_window_ctrl
   import sramw_pkg::*;
#(
   parameter int          ADDR_W       = 24,
   parameter int          DATA_W       = 16,
   parameter int          ARRAY_BYTES  = 1024,
   parameter logic [31:0] CFG_ADDR     = 32'h00FF_FB00,
   parameter logic [31:0] BASEH_ADDR   = 32'h00FF_FB04,
   parameter logic [31:0] BASEL_ADDR   = 32'h00FF_FB06,
   parameter bit          HAS_PWR_MON  = 1'b1,
   parameter bit          SPACE_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_prog,
   input  logic              bus_super,
   input  logic              power_lost,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              acc_done,
   output logic              acc_ignored
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFS_W      = $clog2(ARRAY_BYTES);
   localparam int DEPTH      = ARRAY_BYTES / WORD_BYTES;
   localparam int IDX_W      = $clog2(DEPTH);
   localparam int BASE_W     = ADDR_W - OFS_W;

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("DATA_W must be 16");
      end
      if (ADDR_W <= 16 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 17..32");
      end
      if (OFS_W >= 16 || (1 << OFS_W) != ARRAY_BYTES) begin : g_bad_size
         $error("ARRAY_BYTES must be a power of two below 64 KB");
      end
   endgenerate

   cfg_t              cfg;
   logic              reg_hit;
   logic [BASE_W-1:0] base_field;
   logic [DATA_W-1:0] reg_rdata, reg_rdata_q, arr_rdata;
   logic              arr_cs, arr_we, ignore;
   logic [IDX_W-1:0]  arr_idx;
   logic              sel_arr_q;

   sramw_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
      .CFG_ADDR(CFG_ADDR), .BASEH_ADDR(BASEH_ADDR), .BASEL_ADDR(BASEL_ADDR),
      .HAS_PWR_MON(HAS_PWR_MON)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .power_lost(power_lost), .reg_hit(reg_hit), .cfg(cfg),
      .base_field(base_field), .reg_rdata(reg_rdata)
   );

   sramw_decode #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .SPACE_FILTER(SPACE_FILTER)
   ) i_decode (
      .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
      .prog(bus_prog), .super_acc(bus_super), .reg_hit(reg_hit),
      .base_field(base_field), .cfg(cfg), .arr_cs(arr_cs), .arr_we(arr_we),
      .ignore(ignore), .arr_idx(arr_idx)
   );

   sramw_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_array (
      .clk(clk), .cs(arr_cs), .we(arr_we), .idx(arr_idx),
      .wdata(bus_wdata), .rdata(arr_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid  <= 1'b0;
         acc_done    <= 1'b0;
         acc_ignored <= 1'b0;
         sel_arr_q   <= 1'b0;
         reg_rdata_q <= '0;
      end else begin
         bus_rvalid  <= ~bus_wr & (reg_hit | arr_cs);
         acc_done    <= arr_cs;
         acc_ignored <= ignore;
         sel_arr_q   <= arr_cs;
         if (reg_hit) reg_rdata_q <= reg_rdata;
      end
   end

   assign bus_rdata = sel_arr_q ? arr_rdata : reg_rdata_q;

   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cfg.stop |-> !arr_cs) else $error("array driven in stop"); // R5
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(acc_done && acc_ignored)) else $error("both outcomes pulsed"); // R8
   AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) bus_rvalid |-> $past(bus_req && !bus_wr)) else $error("strobe without read"); // R10

endmodule

// File: tb/test_sram_window_ctrl.sv
module test_sram_window_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0, bus_prog = 1'b1, bus_super = 1'b1;
   logic [23:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        power_lost = 1'b0;
   logic [15:0] bus_rdata;
   logic        bus_rvalid, acc_done, acc_ignored;

   int n_checks = 0, n_fails = 0;
   bit finished = 0;
   logic [15:0] c_rdata;
   logic        c_rvalid, c_ok, c_ign;
   logic        exp_pwr = 1'b0;

   localparam logic [23:0] A_CFG = 24'hFFFB00;
   localparam logic [23:0] A_BH  = 24'hFFFB04;
   localparam logic [23:0] A_BL  = 24'hFFFB06;

   always #10 clk = ~clk;

   sram_window_ctrl i_sram_window_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_prog(bus_prog),
      .bus_super(bus_super), .power_lost(power_lost), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .acc_done(acc_done), .acc_ignored(acc_ignored)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic wr, input logic [23:0] a, input logic [15:0] d,
                      input logic prg, input logic sup);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      bus_prog = prg; bus_super = sup;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
      c_rdata = bus_rdata; c_rvalid = bus_rvalid; c_ok = acc_done; c_ign = acc_ignored;
   endtask

   task automatic rreg(input logic [23:0] a, input logic [15:0] exp, input string tag);
      bus(1'b0, a, 16'h0, 1'b1, 1'b1);
      chk({tag, " data"}, c_rdata, exp);
      chk({tag, " rvalid"}, c_rvalid, 1'b1);
   endtask

   task automatic wreg(input logic [23:0] a, input logic [15:0] d);
      bus(1'b1, a, d, 1'b1, 1'b1);
   endtask

   function automatic logic [15:0] cfgv(input logic [15:0] ctl);
      return ctl | (exp_pwr ? 16'h1000 : 16'h0000);
   endfunction

   task automatic t_reset;
      rreg(A_CFG, 16'h0300, "R1 cfg");
      rreg(A_BH, 16'h0000, "R1 baseh");
      rreg(A_BL, 16'h0000, "R1 basel");
   endtask

   task automatic t_map;
      wreg(A_CFG, 16'hFFFF);
      exp_pwr = 1'b1;
      rreg(A_CFG, 16'h9B00, "R2 all-ones");
      wreg(A_CFG, 16'h0000);
      rreg(A_CFG, 16'h1000, "R7 zero write keeps status");
   endtask

   task automatic t_base;
      wreg(A_BH, 16'hFF12);
      wreg(A_BL, 16'h3456);
      rreg(A_BH, 16'h0012, "R3 baseh");
      rreg(A_BL, 16'h3400, "R3 basel");
      bus(1'b1, 24'h123402, 16'hA5A5, 1'b0, 1'b0);
      chk("R8 write accepted", c_ok, 1'b1);
      chk("R10 no strobe on write", c_rvalid, 1'b0);
      bus(1'b1, 24'h1237FE, 16'h5A5A, 1'b0, 1'b0);
      bus(1'b0, 24'h123402, 16'h0, 1'b0, 1'b0);
      chk("R11 readback", c_rdata, 16'hA5A5);
      chk("R10 read strobe", c_rvalid, 1'b1);
      bus(1'b0, 24'h1237FE, 16'h0, 1'b0, 1'b0);
      chk("R11 top word", c_rdata, 16'h5A5A);
      bus(1'b0, 24'h123800, 16'h0, 1'b0, 1'b0);
      chk("R3 miss ok", c_ok, 1'b0);
      chk("R8 miss ign", c_ign, 1'b0);
      chk("R3 miss rvalid", c_rvalid, 1'b0);
   endtask

   task automatic t_space;
      for (int code = 0; code < 4; code++) begin
         wreg(A_CFG, 16'(code) << 8);
         for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 2; s++) begin
               logic allow;
               allow = (!code[1] || s[0]) && (!code[0] || p[0]);
               bus(1'b0, 24'h123402, 16'h0, p[0], s[0]);
               chk($sformatf("R4 code%0d p%0d s%0d ok", code, p, s), c_ok, allow);
               chk($sformatf("R8 code%0d p%0d s%0d ign", code, p, s), c_ign, !allow);
               chk($sformatf("R10 code%0d p%0d s%0d rvalid", code, p, s), c_rvalid, allow);
               if (allow) chk("R11 data via space", c_rdata, 16'hA5A5);
            end
         end
      end
   endtask

   task automatic t_stop;
      wreg(A_CFG, 16'h8000);
      bus(1'b1, 24'h123402, 16'hBEEF, 1'b1, 1'b1);
      chk("R5 stop write ign", c_ign, 1'b1);
      chk("R5 stop write ok", c_ok, 1'b0);
      bus(1'b0, 24'h123402, 16'h0, 1'b1, 1'b1);
      chk("R5 stop read ign", c_ign, 1'b1);
      chk("R10 stop read rvalid", c_rvalid, 1'b0);
      wreg(A_CFG, 16'h0000);
      bus(1'b0, 24'h123402, 16'h0, 1'b1, 1'b1);
      chk("R5 data untouched in stop", c_rdata, 16'hA5A5);
      @(negedge clk);
      chk("R8 single pulse", {acc_done, acc_ignored}, 2'b00);
   endtask

   task automatic t_lock;
      wreg(A_CFG, 16'h0800);
      wreg(A_BL, 16'h0000);
      wreg(A_BH, 16'h0000);
      rreg(A_BL, 16'h3400, "R6 basel locked");
      rreg(A_BH, 16'h0012, "R6 baseh locked");
      bus(1'b0, 24'h123402, 16'h0, 1'b1, 1'b1);
      chk("R6 window kept", c_ok, 1'b1);
      wreg(A_CFG, 16'h0000);
   endtask

   task automatic t_prio;
      wreg(A_BH, 16'h00FF);
      wreg(A_BL, 16'hF800);
      bus(1'b1, 24'hFFF800, 16'h1111, 1'b0, 1'b0);
      chk("R3 relocated write", c_ok, 1'b1);
      bus(1'b0, A_CFG, 16'h0, 1'b0, 1'b0);
      chk("R9 reg data", c_rdata, cfgv(16'h0000));
      chk("R9 no ok", c_ok, 1'b0);
      chk("R9 no ign", c_ign, 1'b0);
      wreg(A_CFG, 16'h8000);
      bus(1'b0, A_CFG, 16'h0, 1'b0, 1'b0);
      chk("R9 reg in stop", c_rdata, cfgv(16'h8000));
      chk("R9 no ign in stop", c_ign, 1'b0);
      wreg(A_CFG, 16'h0000);
      bus(1'b0, 24'hFFF800, 16'h0, 1'b0, 1'b0);
      chk("R11 relocated read", c_rdata, 16'h1111);
   endtask

   task automatic t_power;
      @(negedge clk); power_lost = 1'b1;
      exp_pwr = 1'b0;
      rreg(A_CFG, 16'h0000, "R7 cleared");
      wreg(A_CFG, 16'h1000);
      rreg(A_CFG, 16'h0000, "R7 no rearm while lost");
      @(negedge clk); power_lost = 1'b0;
      rreg(A_CFG, 16'h0000, "R7 sticky");
      wreg(A_CFG, 16'h1000);
      exp_pwr = 1'b1;
      rreg(A_CFG, 16'h1000, "R7 rearmed");
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_map;
      t_base;
      t_space;
      t_stop;
      t_lock;
      t_prio;
      t_power;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end

endmodule